// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial-peripheral slave that lets a host processor read and write a small bank of 16-bit control registers. The host frames each access with an active-low select line. The first byte it shifts in is a header. The header says whether the access reads or writes and which register it addresses. One or more 16-bit words follow, sent as byte pairs. A write word arrives on the host-to-slave line. A read word leaves on the slave-to-host line. No single access ever moves payload in both directions.

The serial pins are sampled by the block's own clock through a short synchronizer, so edge detection, framing and the register bank all sit in one clock domain. Each committed write raises a one-cycle strobe on a line per register, so neighbouring logic can react to a fresh value. Every register value is also exported as a flat bus. One bit of a configuration register decides what the output line does while the host is not selecting the block. When the bit is set the line is released (output enable low). When it is clear the line is driven low.

Top module: `regacc_spi_slave`

## Requirements
- R1: After reset every register reads 0x0000, except register 7, which reads 0x0C00. No write strobe is active.
- R2: The header is sent MSB first, and each bit is sampled on a rising serial clock edge. Header bit 7 set selects a read and clear selects a write. Bit 6 has no effect. Bits 5:0 give the register address.
- R3: In a write, the first payload byte becomes bits 15:8 and the second becomes bits 7:0. When the second byte completes, the register takes the new word and its strobe line pulses for exactly one clock cycle, with no other strobe active.
- R4: In a read, bit 15 of the addressed register appears on the output after the falling edge that ends the header. Each later falling edge presents the next lower bit. The line holds its value between falling edges.
- R5: In a payload longer than two bytes, every further byte pair addresses the same register. Writes commit again and reads return the register again.
- R6: A read of an address of 8 or above returns 0x0000. A write to such an address changes no register and raises no strobe.
- R7: If the select line rises inside a byte, or after an odd number of payload bytes, the incomplete word is dropped. No strobe fires and the register keeps its old value.
- R8: A read changes no register and raises no strobe, whatever the host shifts in during its payload.
- R9: While the select line is high, output enable equals the inverse of bit 11 of register 7, and the data output is 0.
- R10: During the header and during write payload bytes, the data output is driven 0.
- R11: An asynchronous reset asserted in the middle of an access restores all defaults at once. After release, the next access decodes a fresh header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low access frame |
| spi_mosi | input | 1 | Host-to-slave data |
| spi_miso | output | 1 | Slave-to-host data |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = released) |
| wr_stb | output | NREG (8) | One-cycle commit strobe per register |
| reg_q | output | NREG*16 (128) | Register contents, register i at bits 16*i+15:16*i |

## Verification
A wrong bit counter or phase state shows up within one access. The byte pairing slips, and the bank then shows a value built from the wrong byte boundary. A read of a known register then returns the wrong word. A strobe left stuck or misrouted shows up one cycle after the faulty commit, as an unexpected or missing entry on the strobe lines. The bench compares every strobe against the queue of commits it expects. A framing state that survives a deasserted select line shows up on the next access, which decodes a payload byte as if it were the header.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

   localparam int BYTE_W     = 8;
   localparam int WORD_W     = 16;
   localparam int ADDR_W     = 6;
   localparam int HDR_RD_POS = 7;
   localparam int BITCNT_W   = $clog2(BYTE_W);

   typedef enum logic [1:0] {
      PH_HDR = 2'd0,
      PH_HI  = 2'd1,
      PH_LO  = 2'd2
   } phase_e;

   typedef struct packed {
      logic              rd;
      logic [ADDR_W-1:0] addr;
   } hdr_t;

   function automatic hdr_t hdr_decode(input logic [BYTE_W-1:0] b);
      hdr_t h;
      h.rd   = b[HDR_RD_POS];
      h.addr = b[ADDR_W-1:0];
      return h;
   endfunction

endpackage

// File: rtl/regacc_sync.sv
module regacc_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4)
         else $error("regacc_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
   import regacc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic [WORD_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_req_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              tx_bit_o,
   output logic              cs_act_o
);

   logic                sclk_q;
   logic                cs_act, rise, fall;
   logic [BITCNT_W-1:0] bit_cnt;
   phase_e              phase;
   logic [BYTE_W-1:0]   rx_q, byte_nxt;
   logic [BYTE_W-1:0]   hi_q;
   logic                rd_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [WORD_W-1:0]   tx_q;
   logic                load_pend;
   logic                wr_req;
   logic [WORD_W-1:0]   wr_data;
   hdr_t                hdr;

   assign cs_act   = ~cs_n_s;
   assign rise     = cs_act &  sclk_s & ~sclk_q;
   assign fall     = cs_act & ~sclk_s &  sclk_q;
   assign byte_nxt = {rx_q[BYTE_W-2:0], mosi_s};
   assign hdr      = hdr_decode(byte_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         phase     <= PH_HDR;
         rx_q      <= '0;
         hi_q      <= '0;
         rd_q      <= 1'b0;
         addr_q    <= '0;
         tx_q      <= '0;
         load_pend <= 1'b0;
         wr_req    <= 1'b0;
         wr_data   <= '0;
      end else if (!cs_act) begin
         bit_cnt   <= '0;
         phase     <= PH_HDR;
         tx_q      <= '0;
         load_pend <= 1'b0;
         wr_req    <= 1'b0;
      end else begin
         wr_req <= 1'b0;
         if (rise) begin
            rx_q    <= byte_nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BITCNT_W'(BYTE_W-1)) begin
               unique case (phase)
                  PH_HDR: begin
                     rd_q      <= hdr.rd;
                     addr_q    <= hdr.addr;
                     load_pend <= hdr.rd;
                     phase     <= PH_HI;
                  end
                  PH_HI: begin
                     hi_q  <= byte_nxt;
                     phase <= PH_LO;
                  end
                  PH_LO: begin
                     if (rd_q) begin
                        load_pend <= 1'b1;
                     end else begin
                        wr_req  <= 1'b1;
                        wr_data <= {hi_q, byte_nxt};
                     end
                     phase <= PH_HI;
                  end
                  default: phase <= PH_HDR;
               endcase
            end
         end
         if (fall) begin
            if (load_pend) begin
               tx_q      <= rd_data;
               load_pend <= 1'b0;
            end else begin
               tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
         end
      end
   end

   assign addr_o    = addr_q;
   assign wr_req_o  = wr_req;
   assign wr_data_o = wr_data;
   assign tx_bit_o  = tx_q[WORD_W-1];
   assign cs_act_o  = cs_act;

   // R8: a commit never belongs to a read access
   p_no_commit_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !rd_q);

   // R4: the shift word only moves on a falling serial edge
   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !fall) |=> $stable(tx_q));

   // R7: an idle select line leaves the framing at its start
   p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (phase == PH_HDR && bit_cnt == '0 && !wr_req));

endmodule

// File: rtl/regacc_regfile.sv
module regacc_regfile
   import regacc_pkg::*;
#(
   parameter int                NREG      = 8,
   parameter int                CFG_IDX   = 7,
   parameter logic [WORD_W-1:0] CFG_RESET = 16'h0C00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_req,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [WORD_W-1:0]      wr_data,
   output logic [WORD_W-1:0]      rd_data,
   output logic [NREG-1:0]        wr_stb,
   output logic [NREG*WORD_W-1:0] reg_q
);

   initial begin
      assert (NREG >= 1 && NREG <= (1 << ADDR_W))
         else $error("regacc_regfile: NREG out of range");
      assert (CFG_IDX >= 0 && CFG_IDX < NREG)
         else $error("regacc_regfile: CFG_IDX outside bank");
   end

   logic [WORD_W-1:0] words [NREG];
   logic              impl;

   assign impl = ({1'b0, addr} < (ADDR_W+1)'(NREG));

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         localparam logic [WORD_W-1:0] RV = (g == CFG_IDX) ? CFG_RESET : '0;
         logic              hit;
         logic [WORD_W-1:0] word_q;
         logic              stb_q;

         assign hit = wr_req && (addr == ADDR_W'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= RV;
               stb_q  <= 1'b0;
            end else begin
               stb_q <= hit;
               if (hit) word_q <= wr_data;
            end
         end

         assign words[g]                    = word_q;
         assign wr_stb[g]                   = stb_q;
         assign reg_q[g*WORD_W +: WORD_W]   = word_q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (addr == ADDR_W'(i)) rd_data = words[i];
      end
   end

   // R3: at most one strobe per cycle
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));

   // R3: the bank only changes on a commit request
   p_hold_without_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> $stable(reg_q));

   // R6: commits to unimplemented addresses stay silent
   p_unimpl_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !impl) |=> (wr_stb == '0));

endmodule

// File: rtl/regacc_spi_slave.sv
module regacc_spi_slave
   import regacc_pkg::*;
#(
   parameter int                NREG        = 8,
   parameter int                SYNC_STAGES = 2,
   parameter int                CFG_IDX     = 7,
   parameter int                HIZ_BIT     = 11,
   parameter logic [WORD_W-1:0] CFG_RESET   = 16'h0C00
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   spi_sclk,
   input  logic                   spi_cs_n,
   input  logic                   spi_mosi,
   output logic                   spi_miso,
   output logic                   spi_miso_oe,
   output logic [NREG-1:0]        wr_stb,
   output logic [NREG*WORD_W-1:0] reg_q
);

   initial begin
      assert (HIZ_BIT >= 0 && HIZ_BIT < WORD_W)
         else $error("regacc_spi_slave: HIZ_BIT outside word");
   end

   logic [2:0]        pins_s;
   logic              sclk_s, cs_n_s, mosi_s;
   logic [ADDR_W-1:0] addr;
   logic              wr_req;
   logic [WORD_W-1:0] wr_data, rd_data;
   logic              tx_bit, cs_act;
   logic              idle_release;

   regacc_sync #(
      .STAGES  (SYNC_STAGES),
      .W       (3),
      .RST_VAL (3'b100)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     (pins_s)
   );

   assign {cs_n_s, sclk_s, mosi_s} = pins_s;

   regacc_engine engine_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .cs_n_s    (cs_n_s),
      .mosi_s    (mosi_s),
      .rd_data   (rd_data),
      .addr_o    (addr),
      .wr_req_o  (wr_req),
      .wr_data_o (wr_data),
      .tx_bit_o  (tx_bit),
      .cs_act_o  (cs_act)
   );

   regacc_regfile #(
      .NREG      (NREG),
      .CFG_IDX   (CFG_IDX),
      .CFG_RESET (CFG_RESET)
   ) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (wr_req),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .wr_stb  (wr_stb),
      .reg_q   (reg_q)
   );

   assign idle_release = reg_q[CFG_IDX*WORD_W + HIZ_BIT];
   assign spi_miso_oe  = cs_act | ~idle_release;
   assign spi_miso     = cs_act & tx_bit;

   // R7: a strobe only follows a cycle inside an access frame
   p_strobe_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |-> $past(cs_act));

   // R9: with the frame idle the data line never carries a one
   p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |-> !spi_miso);

endmodule

// File: tb/regacc_spi_slave_tb.sv
module regacc_spi_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int NREG       = 8;
   localparam int WD_CYCLES  = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe;
   logic [NREG-1:0]    wr_stb;
   logic [NREG*16-1:0] reg_q;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   logic [7:0]  pay [8];
   logic [7:0]  got [8];
   logic [15:0] rd_word;
   event        rd_ev;

   logic [15:0] exp_rd_q [$];
   string       exp_rd_tag [$];
   int          exp_wr_idx [$];
   logic [15:0] exp_wr_val [$];
   string       exp_wr_tag [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   regacc_spi_slave dut_i (
      .clk (clk), .rst_n (rst_n), .spi_sclk (spi_sclk), .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi), .spi_miso (spi_miso), .spi_miso_oe (spi_miso_oe),
      .wr_stb (wr_stb), .reg_q (reg_q)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] rv(input int i);
      return (i == 7) ? 16'h0C00 : 16'h0000;
   endfunction

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = spi_miso;
         spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b0;
      end
   endtask

   task automatic spi_begin();
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic spi_end();
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   // header plus n payload bytes from pay[]; read words go to the monitor
   task automatic spi_xact(input logic [7:0] hdr, input int n);
      logic [7:0] dummy;
      spi_begin();
      spi_byte(hdr, dummy);
      chk(dummy == 8'h00, "R10 header miso", {24'd0, dummy}, 32'd0);
      for (int i = 0; i < n; i++) begin
         spi_byte(pay[i], got[i]);
         if (hdr[7] && (i % 2 == 1)) begin
            rd_word = {got[i-1], got[i]};
            -> rd_ev;
         end
      end
      spi_end();
      if (!hdr[7]) begin
         for (int i = 0; i < n; i++)
            chk(got[i] == 8'h00, "R10 write miso", {24'd0, got[i]}, 32'd0);
      end
   endtask

   task automatic exp_wr(input int idx, input logic [15:0] v, input string tag);
      exp_wr_idx.push_back(idx);
      exp_wr_val.push_back(v);
      exp_wr_tag.push_back(tag);
   endtask

   task automatic exp_rd(input logic [15:0] v, input string tag);
      exp_rd_q.push_back(v);
      exp_rd_tag.push_back(tag);
   endtask

   task automatic set_pay2(input logic [15:0] w);
      pay[0] = w[15:8];
      pay[1] = w[7:0];
   endtask

   // read-word monitor
   initial begin
      forever begin
         @(rd_ev);
         if (exp_rd_q.size() == 0) begin
            chk(1'b0, "R4 unexpected read word", {16'd0, rd_word}, 32'd0);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_rd_q.pop_front();
            t = exp_rd_tag.pop_front();
            chk(rd_word == e, t, {16'd0, rd_word}, {16'd0, e});
         end
      end
   end

   // strobe monitor
   always @(negedge clk) begin
      if (rst_n && (|wr_stb)) begin
         if (exp_wr_idx.size() == 0) begin
            chk(1'b0, "R3/R6/R7/R8 unexpected strobe", {24'd0, wr_stb}, 32'd0);
         end else begin
            int idx;
            logic [15:0] v;
            string t;
            idx = exp_wr_idx.pop_front();
            v = exp_wr_val.pop_front();
            t = exp_wr_tag.pop_front();
            chk(wr_stb == (8'd1 << idx), {t, " strobe"}, {24'd0, wr_stb}, {24'd0, 8'd1 << idx});
            chk(reg_q[idx*16 +: 16] == v, {t, " value"}, {16'd0, reg_q[idx*16 +: 16]}, {16'd0, v});
         end
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=done", WD_CYCLES);
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] dummy;
      repeat (4) @(negedge clk);
      // R1: reset state
      for (int i = 0; i < NREG; i++)
         chk(reg_q[i*16 +: 16] == rv(i), "R1 reset value", {16'd0, reg_q[i*16 +: 16]}, {16'd0, rv(i)});
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(wr_stb == '0, "R1 strobes idle", {24'd0, wr_stb}, 32'd0);
      // R9: bit 11 of register 7 set -> released
      chk(spi_miso_oe == 1'b0, "R9 idle release", {31'd0, spi_miso_oe}, 32'd0);

      // R3: plain write, R2 address decode
      set_pay2(16'hA55A); exp_wr(3, 16'hA55A, "R3 write reg3");
      spi_xact(8'h03, 2);
      // R4/R2: read back
      exp_rd(16'hA55A, "R4 read reg3");
      spi_xact(8'h83, 2);
      // R2: bit 6 ignored for read and write
      exp_rd(16'hA55A, "R2 read with bit6");
      spi_xact(8'hC3, 2);
      set_pay2(16'h1234); exp_wr(5, 16'h1234, "R2 write with bit6");
      spi_xact(8'h45, 2);

      // R5: four-byte write and read hit one register
      pay[0] = 8'h11; pay[1] = 8'h11; pay[2] = 8'h22; pay[3] = 8'h22;
      exp_wr(1, 16'h1111, "R5 first word"); exp_wr(1, 16'h2222, "R5 second word");
      spi_xact(8'h01, 4);
      exp_rd(16'h2222, "R5 reread 1"); exp_rd(16'h2222, "R5 reread 2");
      spi_xact(8'h81, 4);

      // R6: unimplemented addresses
      exp_rd(16'h0000, "R6 read unimpl");
      spi_xact(8'hA0, 2);
      set_pay2(16'hFFFF);
      spi_xact(8'h3F, 2);
      for (int i = 0; i < NREG; i++) begin
         logic [15:0] e;
         e = (i == 1) ? 16'h2222 : (i == 3) ? 16'hA55A : (i == 5) ? 16'h1234 : rv(i);
         chk(reg_q[i*16 +: 16] == e, "R6 bank unchanged", {16'd0, reg_q[i*16 +: 16]}, {16'd0, e});
      end

      // R7: odd payload, only the full word commits
      pay[0] = 8'hBE; pay[1] = 8'hEF; pay[2] = 8'h77;
      exp_wr(2, 16'hBEEF, "R7 odd payload");
      spi_xact(8'h02, 3);
      chk(reg_q[2*16 +: 16] == 16'hBEEF, "R7 odd tail dropped", {16'd0, reg_q[2*16 +: 16]}, 32'h0000BEEF);
      // R7: abort inside a byte
      spi_begin();
      spi_byte(8'h02, dummy);
      spi_byte(8'h99, dummy);
      for (int i = 0; i < 4; i++) begin
         spi_mosi = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sclk = 1'b0;
      end
      spi_end();
      chk(reg_q[2*16 +: 16] == 16'hBEEF, "R7 mid-byte abort", {16'd0, reg_q[2*16 +: 16]}, 32'h0000BEEF);

      // R8: read with busy MOSI changes nothing
      pay[0] = 8'hFF; pay[1] = 8'hFF;
      exp_rd(16'hA55A, "R8 read busy mosi");
      spi_xact(8'h83, 2);
      chk(reg_q[3*16 +: 16] == 16'hA55A, "R8 reg unchanged", {16'd0, reg_q[3*16 +: 16]}, 32'h0000A55A);

      // R9: clear release bit -> driven low when idle
      set_pay2(16'h0000); exp_wr(7, 16'h0000, "R9 cfg clear");
      spi_xact(8'h07, 2);
      chk(spi_miso_oe == 1'b1, "R9 idle driven", {31'd0, spi_miso_oe}, 32'd1);
      chk(spi_miso == 1'b0, "R9 idle low", {31'd0, spi_miso}, 32'd0);
      set_pay2(16'h0800); exp_wr(7, 16'h0800, "R9 cfg set");
      spi_xact(8'h07, 2);
      chk(spi_miso_oe == 1'b0, "R9 idle release again", {31'd0, spi_miso_oe}, 32'd0);

      // R11: async reset in the middle of an access
      spi_begin();
      spi_byte(8'h03, dummy);
      spi_byte(8'hAB, dummy);
      rst_n = 1'b0;
      #1;
      for (int i = 0; i < NREG; i++)
         chk(reg_q[i*16 +: 16] == rv(i), "R11 async defaults", {16'd0, reg_q[i*16 +: 16]}, {16'd0, rv(i)});
      repeat (3) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      set_pay2(16'h00C3); exp_wr(4, 16'h00C3, "R11 fresh write");
      spi_xact(8'h04, 2);
      exp_rd(16'h00C3, "R11 fresh read");
      spi_xact(8'h84, 2);

      repeat (20) @(negedge clk);
      chk(exp_wr_idx.size() == 0, "R3 missing strobes", exp_wr_idx.size(), 32'd0);
      chk(exp_rd_q.size() == 0, "R4 missing read words", exp_rd_q.size(), 32'd0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule